// File: doc/BRIEF.md
# Auxiliary Register Address Generator

This block produces data-memory addresses for a DSP datapath. It keeps eight 24-bit pointer registers, two stride registers and one circular block-length register. Each request names a pointer, an update mode and a step source. One cycle later the block presents the effective address, and in the same clock edge it writes the updated pointer back.

Linear updates add or subtract a step, either before the access (the new value is the address) or after it (the old value is the address). Two circular modes keep a pointer inside a buffer whose length comes from the block-length register. The buffer is aligned to the smallest power of two that is not below that length. A reverse-carry mode walks a buffer in bit-reversed order for radix-2 FFT passes. A load port writes any register, and a combinational read port returns any register.

Top module: `ar_addr_gen`

## Requirements
- R1: After reset, all pointer, stride and block-length registers read 0 and `ea_valid` is low.
- R2: Load and read select codes are: 0 to 7 for pointers 0 to 7, 8 for stride A, 9 for stride B, 10 for block length. `rd_data` shows the selected register in the same cycle. Codes 11 to 15 read 0, and a load with one of those codes changes no register.
- R3: `ea` and `ea_valid` are registered. They show the result of a request on the clock edge that takes the request. The written-back pointer can be read right after that edge.
- R4: Mode 1 (pre-add) and mode 2 (pre-subtract) write pointer±step back and output that new value as `ea`.
- R5: Mode 3 (post-add) and mode 4 (post-subtract) output the old pointer as `ea` and write pointer±step back.
- R6: `req_step` selects the step: 0 gives 1, 1 gives stride A, 2 gives stride B, 3 gives `req_disp` zero-extended.
- R7: Mode 0 outputs the pointer as `ea` and leaves it unchanged.
- R8: Mode 5 (circular post-add) and mode 6 (circular post-subtract) output the old pointer. Let L be the block length and 2^k the smallest power of two with 2^k ≥ L. The buffer base is the pointer with its low k bits cleared. A result at or above base+L has L subtracted, and a result below the base has L added. With L = 0 these modes act as modes 3 and 4.
- R9: Mode 7 outputs the old pointer and writes back the pointer plus the step, with the carry running from bit 23 toward bit 0. A stride of N/2 on an N-aligned pointer therefore visits offsets in bit-reversed order.
- R10: Linear updates wrap modulo 2^24.
- R11: When a load and a write-back target the same pointer in one cycle, the loaded value wins. A stride or block-length load in the same cycle as a request takes effect only for later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Address request |
| req_sel | input | 3 | Pointer number |
| req_mode | input | 3 | Update mode, codes per R4, R5, R7, R8, R9 |
| req_step | input | 2 | Step source, codes per R6 |
| req_disp | input | 8 | Displacement step |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 4 | Load target code, per R2 |
| ld_data | input | 24 | Load value |
| rd_sel | input | 4 | Read select code, per R2 |
| rd_data | output | 24 | Selected register value |
| ea | output | 24 | Effective address |
| ea_valid | output | 1 | `ea` holds a request result |

## Verification
A wrong pointer update does not show in the address of the request that caused it, because post modes output the old value. The error shows in `rd_data` right after the edge, and in `ea` on the next request to the same pointer. A bad circular base or reverse-carry chain therefore first shows as a skipped or repeated offset in a sequence. For that reason the bench runs whole wrap and reverse-order sequences rather than single steps. A priority error between load and write-back appears in the read-back in the cycle after the collision.

// File: rtl/ar_addr_gen.sv
module ar_addr_gen #(
  parameter int AW    = 24,
  parameter int NAR   = 8,
  parameter int DISPW = 8,
  localparam int SELW = $clog2(NAR),
  localparam int RSW  = $clog2(NAR + 3)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [SELW-1:0]  req_sel,
  input  logic [2:0]       req_mode,
  input  logic [1:0]       req_step,
  input  logic [DISPW-1:0] req_disp,
  input  logic             ld_en,
  input  logic [RSW-1:0]   ld_sel,
  input  logic [AW-1:0]    ld_data,
  input  logic [RSW-1:0]   rd_sel,
  output logic [AW-1:0]    rd_data,
  output logic [AW-1:0]    ea,
  output logic             ea_valid
);
  localparam logic [2:0] M_NOP = 3'd0, M_PREA = 3'd1, M_PRES = 3'd2, M_POSTA = 3'd3,
                         M_POSTS = 3'd4, M_CIRA = 3'd5, M_CIRS = 3'd6, M_BREV = 3'd7;
  localparam logic [RSW-1:0] C_IRA = RSW'(NAR), C_IRB = RSW'(NAR + 1), C_BLK = RSW'(NAR + 2);

  logic [AW-1:0] ar [NAR];
  logic [AW-1:0] ir_a, ir_b, blk;

  function automatic logic [AW-1:0] flip(input logic [AW-1:0] x);
    for (int i = 0; i < AW; i++) flip[i] = x[AW-1-i];
  endfunction

  logic [AW-1:0] cur, step, nxt, mask, base;
  logic [AW:0]   top, addc, subc;
  logic          under;

  assign cur = ar[req_sel];

  always_comb begin
    case (req_step)
      2'd0:    step = AW'(1);
      2'd1:    step = ir_a;
      2'd2:    step = ir_b;
      default: step = AW'(req_disp);
    endcase
  end

  always_comb begin
    mask = '0;
    for (int i = 0; i < AW; i++)
      if (((blk - AW'(1)) >> i) != '0) mask = (AW'(1) << (i + 1)) - AW'(1);
  end

  assign base  = cur & ~mask;
  assign top   = {1'b0, base} + {1'b0, blk};
  assign addc  = {1'b0, cur} + {1'b0, step};
  assign subc  = {1'b0, cur} - {1'b0, step};
  assign under = subc[AW] || (subc[AW-1:0] < base);

  always_comb begin
    case (req_mode)
      M_PREA, M_POSTA: nxt = addc[AW-1:0];
      M_PRES, M_POSTS: nxt = subc[AW-1:0];
      M_CIRA: nxt = (blk != '0 && addc >= top) ? addc[AW-1:0] - blk : addc[AW-1:0];
      M_CIRS: nxt = (blk != '0 && under) ? subc[AW-1:0] + blk : subc[AW-1:0];
      M_BREV: nxt = flip(flip(cur) + flip(step));
      default: nxt = cur;
    endcase
  end

  logic wr_back;
  assign wr_back = req_valid && (req_mode != M_NOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NAR; i++) ar[i] <= '0;
      ir_a     <= '0;
      ir_b     <= '0;
      blk      <= '0;
      ea       <= '0;
      ea_valid <= 1'b0;
    end else begin
      for (int i = 0; i < NAR; i++) begin
        if (ld_en && ld_sel == RSW'(i)) ar[i] <= ld_data;
        else if (wr_back && req_sel == SELW'(i)) ar[i] <= nxt;
      end
      if (ld_en && ld_sel == C_IRA) ir_a <= ld_data;
      if (ld_en && ld_sel == C_IRB) ir_b <= ld_data;
      if (ld_en && ld_sel == C_BLK) blk  <= ld_data;
      ea_valid <= req_valid;
      if (req_valid) ea <= (req_mode == M_PREA || req_mode == M_PRES) ? nxt : cur;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_sel < C_IRA) rd_data = ar[rd_sel[SELW-1:0]];
    else if (rd_sel == C_IRA) rd_data = ir_a;
    else if (rd_sel == C_IRB) rd_data = ir_b;
    else if (rd_sel == C_BLK) rd_data = blk;
  end

  logic coll;
  assign coll = ld_en && ld_sel == RSW'(req_sel);

  p_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid |-> $past(req_valid));

  p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en && ld_sel < C_IRA |=> ar[$past(ld_sel[SELW-1:0])] == $past(ld_data));

  p_pre_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_mode == M_PREA || req_mode == M_PRES) && !coll
    |=> ar[$past(req_sel)] == ea);

  p_nop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_mode == M_NOP && !coll
    |=> ar[$past(req_sel)] == ea);

  p_circ_inside_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_mode == M_CIRA || req_mode == M_CIRS) && !coll && blk != '0
      && step <= blk && cur >= base && {1'b0, cur} < top
    |=> ar[$past(req_sel)] >= $past(base) && {1'b0, ar[$past(req_sel)]} < $past(top));
endmodule

// File: tb/tb_ar_addr_gen.sv
module tb_ar_addr_gen;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, ld_en = 0;
  logic [2:0] req_sel = 0, req_mode = 0;
  logic [1:0] req_step = 0;
  logic [7:0] req_disp = 0;
  logic [3:0] ld_sel = 0, rd_sel = 0;
  logic [23:0] ld_data = 0, rd_data, ea;
  logic ea_valid;
  int checks = 0, fails = 0;
  logic [23:0] sh [8];
  logic [23:0] sa, sb;

  always #4 clk = ~clk;

  ar_addr_gen dut (.*);

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [3:0] s, input logic [23:0] d);
    @(negedge clk); ld_en = 1; ld_sel = s; ld_data = d;
    @(posedge clk); #1 ld_en = 0;
  endtask

  task automatic issue(input logic [2:0] s, input logic [2:0] m, input logic [1:0] st,
                       input logic [7:0] d);
    @(negedge clk); req_valid = 1; req_sel = s; req_mode = m; req_step = st; req_disp = d;
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic readback(input string tag, input logic [3:0] s, input logic [23:0] exp);
    rd_sel = s; #1 chk(tag, rd_data, exp);
  endtask

  function automatic logic [23:0] stepv(input logic [1:0] st, input logic [7:0] d);
    case (st) 2'd0: return 24'd1; 2'd1: return sa; 2'd2: return sb; default: return {16'd0, d}; endcase
  endfunction

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [23:0] old, nv, s, off;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ea_valid", {23'd0, ea_valid}, 24'd0);
    for (int r = 0; r < 11; r++) readback("R1 reset reg", r[3:0], 24'd0);
    @(negedge clk); rst_n = 1;

    sa = 24'h000013; sb = 24'h7FFFF1;
    load(4'd8, sa); load(4'd9, sb);
    readback("R2 stride A", 4'd8, sa);
    readback("R2 stride B", 4'd9, sb);
    load(4'd12, 24'hABCDEF);
    readback("R2 bad code reads 0", 4'd12, 24'd0);
    for (int r = 0; r < 11; r++)
      readback("R2 bad load ignored", r[3:0], r == 8 ? sa : r == 9 ? sb : 24'd0);

    // R4 R5 R6 R10: linear sweep over pointers, modes and step sources
    for (int p = 0; p < 8; p++) begin
      sh[p] = (p == 0) ? 24'hFFFFFE : (p == 1) ? 24'h000001 : 24'h012345 * (p + 1);
      load(p[3:0], sh[p]);
      for (int m = 1; m <= 4; m++)
        for (int st = 0; st < 4; st++) begin
          old = sh[p];
          s = stepv(st[1:0], 8'hA5);
          nv = (m == 1 || m == 3) ? old + s : old - s;
          issue(p[2:0], m[2:0], st[1:0], 8'hA5);
          chk("R3 ea_valid", {23'd0, ea_valid}, 24'd1);
          chk((m <= 2) ? "R4 pre ea" : "R5 post ea", ea, (m <= 2) ? nv : old);
          readback("R6 R10 writeback", p[3:0], nv);
          sh[p] = nv;
        end
    end
    @(posedge clk); #1 chk("R3 ea_valid drops", {23'd0, ea_valid}, 24'd0);

    load(4'd0, 24'hFFFFFF);
    issue(3'd0, 3'd3, 2'd0, 8'd0);
    readback("R10 top wrap", 4'd0, 24'd0);
    issue(3'd0, 3'd2, 2'd0, 8'd0);
    chk("R10 bottom wrap", ea, 24'hFFFFFF);

    issue(3'd4, 3'd0, 2'd1, 8'd0);
    chk("R7 nop ea", ea, sh[4]);
    readback("R7 nop hold", 4'd4, sh[4]);

    // R8: length 6, base 0x40, up by 1 then down by 4
    load(4'd10, 24'd6); load(4'd1, 24'h40);
    off = 0;
    for (int i = 0; i < 14; i++) begin
      issue(3'd1, 3'd5, 2'd0, 8'd0);
      chk("R8 circ up", ea, 24'h40 + 24'(i % 6));
    end
    off = 24'd14 % 6;
    load(4'd9, 24'd4); sb = 24'd4;
    for (int i = 0; i < 12; i++) begin
      issue(3'd1, 3'd6, 2'd2, 8'd0);
      chk("R8 circ down", ea, 24'h40 + off);
      off = (off + 6 - 4) % 6;
    end
    // R8: power-of-two length 8, pointer 0x7D, displacement 3
    load(4'd10, 24'd8); load(4'd5, 24'h7D);
    for (int i = 0; i < 16; i++) begin
      issue(3'd5, 3'd5, 2'd3, 8'd3);
      chk("R8 circ len8", ea, 24'h78 + 24'((5 + 3 * i) % 8));
    end
    load(4'd10, 24'd0); load(4'd6, 24'h000002);
    issue(3'd6, 3'd6, 2'd3, 8'd5);
    readback("R8 zero length linear", 4'd6, 24'hFFFFFD);

    // R9: bit-reversed order, N=8 and N=16
    load(4'd8, 24'd4); sa = 24'd4; load(4'd2, 24'h200);
    for (int i = 0; i < 16; i++) begin
      issue(3'd2, 3'd7, 2'd1, 8'd0);
      chk("R9 brev N8", ea, 24'h200 + {21'd0, i[0], i[1], i[2]});
    end
    load(4'd7, 24'h3A0);
    for (int i = 0; i < 16; i++) begin
      issue(3'd7, 3'd7, 2'd3, 8'd8);
      chk("R9 brev N16", ea, 24'h3A0 + {20'd0, i[0], i[1], i[2], i[3]});
    end

    // R11: same-cycle load beats write-back; same-cycle stride load is late
    load(4'd3, 24'h000100);
    @(negedge clk);
    req_valid = 1; req_sel = 3; req_mode = 3'd3; req_step = 2'd0;
    ld_en = 1; ld_sel = 4'd3; ld_data = 24'h000123;
    @(posedge clk); #1 req_valid = 0; ld_en = 0;
    chk("R11 ea old", ea, 24'h000100);
    readback("R11 load wins", 4'd3, 24'h000123);
    @(negedge clk);
    req_valid = 1; req_sel = 3; req_mode = 3'd1; req_step = 2'd1;
    ld_en = 1; ld_sel = 4'd8; ld_data = 24'h000010;
    @(posedge clk); #1 req_valid = 0; ld_en = 0;
    chk("R11 old stride used", ea, 24'h000127);
    issue(3'd3, 3'd1, 2'd1, 8'd0);
    chk("R11 new stride later", ea, 24'h000137);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule